// File: doc/BRIEF.md
# Tri-Level Pulse Up/Down Step Counter

This block turns one three-level control line into single-step adjustments of an 8-bit setting code that feeds a DAC. Two comparator flags describe the line. One flag reports the low level and the other reports the high level. When neither flag is set, the line is at mid level, which is also its idle level when nothing drives it. An excursion to low followed by a return to mid raises the code by one step. An excursion to high followed by a return to mid lowers it by one step.

Every excursion is qualified before it can count. The flags are synchronised to the clock. A deglitch filter then removes level changes that are too short. The filtered excursion must be long enough to count. Accepted counts must be spaced apart, and a start delay after the enable rises must have passed. Each accepted count produces a one-cycle strobe. All timing thresholds are parameters given in clock cycles.

The block has no data stream. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure. The enable and the two flags are sampled on every clock.

Top module: `tri_level_step_counter`

## Requirements
- R1: A low excursion that lasts at least VALID_CYC filtered cycles and then returns to mid increments the code by one.
- R2: A high excursion that lasts at least VALID_CYC filtered cycles and then returns to mid decrements the code by one.
- R3: The code saturates at 255 on increment and at 0 on decrement, and never wraps. An accepted command at a limit leaves the code unchanged and still pulses the strobe.
- R4: An excursion shorter than VALID_CYC cycles produces no count and no strobe.
- R5: A level change on the synchronised line that persists for fewer than REJECT_CYC consecutive cycles is ignored. It neither starts an excursion nor ends one, so a short mid blip inside a low excursion does not split it.
- R6: While cnt_en is low, no excursion changes the code or pulses the strobe.
- R7: After the synchronised enable rises, no count is accepted until START_CYC cycles have passed.
- R8: A count attempt that arrives fewer than GAP_CYC cycles after the previous accepted count is ignored.
- R9: A direct change from low to high, or from high to low, produces no count and restarts the width timer for the new level.
- R10: Each accepted count pulses step_stb high for exactly one cycle, in the same cycle that the updated code appears. The strobe never stays high for two cycles in a row.
- R11: After reset, dac_code equals INIT_CODE (0 by default) and step_stb is low.
- R12: Both flags set at once is treated as the mid level. A valid low excursion that ends with both flags set therefore counts as an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counting enable, asynchronous to clk |
| line_lo | input | 1 | Comparator flag: control line at low level |
| line_hi | input | 1 | Comparator flag: control line at high level |
| dac_code | output | CODE_W (8) | Current setting code |
| step_stb | output | 1 | One-cycle pulse for each accepted count |

## Verification
A return to mid reaches dac_code and step_stb SYNC_STAGES + REJECT_CYC + 1 rising edges after the flags change. That is 6 edges with the bench parameters. After every excursion, the bench holds the line at mid for GAP_CYC + 10 cycles. This covers both that latency and the spacing window, so the bench compares the code only after the result is due and the next command is free to count. Strobes are counted on falling edges over the whole run. The bench checks its running total against the number of counts that the requirements predict.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  typedef enum logic [1:0] {
    LV_MID = 2'd0,
    LV_LO  = 2'd1,
    LV_HI  = 2'd2
  } lvl_e;

  // Both flags or neither flag set: the line reads as mid (R12)
  function automatic lvl_e classify(input logic lo, input logic hi);
    if (lo && !hi)      return LV_LO;
    else if (hi && !lo) return LV_HI;
    else                return LV_MID;
  endfunction

endpackage

// File: rtl/tlc_sync_filter.sv
module tlc_sync_filter
  import tlc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REJECT_CYC  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lo_raw,
  input  logic hi_raw,
  input  logic en_raw,
  output lvl_e lvl_f,
  output logic en_s
);
  localparam int NS = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;
  localparam int RW = $clog2(REJECT_CYC + 1) + 1;
  localparam logic [RW-1:0] REJ = RW'(REJECT_CYC);

  logic [NS-1:0][2:0] chain_q;
  logic [2:0] sync_w;
  lvl_e lvl_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= {en_raw, hi_raw, lo_raw};
      for (int i = 1; i < NS; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign sync_w  = chain_q[NS-1];
  assign en_s    = sync_w[2];
  assign lvl_raw = classify(sync_w[0], sync_w[1]);

  generate
    if (REJECT_CYC <= 1) begin : g_nofilt
      lvl_e filt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) filt_q <= LV_MID;
        else        filt_q <= lvl_raw;
      end
      assign lvl_f = filt_q;
    end else begin : g_filt
      lvl_e last_q, filt_q;
      logic [RW-1:0] run_q, len_now;

      always_comb begin
        if (lvl_raw == last_q) len_now = (run_q == REJ) ? REJ : run_q + 1'b1;
        else                   len_now = RW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          last_q <= LV_MID;
          run_q  <= '0;
          filt_q <= LV_MID;
        end else begin
          last_q <= lvl_raw;
          run_q  <= len_now;
          if (len_now >= REJ) filt_q <= lvl_raw;
        end
      end

      assign lvl_f = filt_q;

      // R5
      filt_follows_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> ($past(lvl_raw) == filt_q));
    end
  endgenerate

endmodule

// File: rtl/tlc_width_qual.sv
module tlc_width_qual
  import tlc_pkg::*;
#(
  parameter int VALID_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  lvl_e lvl_f,
  output logic req_up,
  output logic req_dn
);
  localparam int WW = $clog2(VALID_CYC + 1) + 1;
  localparam logic [WW-1:0] VLD = WW'(VALID_CYC);

  lvl_e cur_q;
  logic [WW-1:0] wid_q;
  logic chg, long_enough;

  assign chg         = (lvl_f != cur_q);
  assign long_enough = (wid_q >= VLD);
  assign req_up      = chg && (lvl_f == LV_MID) && (cur_q == LV_LO) && long_enough;
  assign req_dn      = chg && (lvl_f == LV_MID) && (cur_q == LV_HI) && long_enough;

  // Width restarts on every filtered change, including low<->high (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= LV_MID;
      wid_q <= '0;
    end else begin
      cur_q <= lvl_f;
      if (chg)               wid_q <= WW'(1);
      else if (wid_q != VLD) wid_q <= wid_q + 1'b1;
    end
  end

  // R1
  mid_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_f == LV_MID && $past(lvl_f) == LV_MID) |-> !(req_up || req_dn));

endmodule

// File: rtl/tlc_count_gate.sv
module tlc_count_gate #(
  parameter int START_CYC = 50,
  parameter int GAP_CYC   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  input  logic req_up,
  input  logic req_dn,
  output logic acc_up,
  output logic acc_dn
);
  localparam int SW = $clog2(START_CYC + 1) + 1;
  localparam int GW = $clog2(GAP_CYC + 1) + 1;
  localparam logic [SW-1:0] START_L  = SW'(START_CYC);
  localparam logic [GW-1:0] GAP_LOAD = (GAP_CYC > 0) ? GW'(GAP_CYC - 1) : '0;

  logic [SW-1:0] start_q;
  logic [GW-1:0] gap_q;
  logic armed, open, acc_any;

  assign armed   = (start_q == START_L);
  assign open    = en_s && armed && (gap_q == '0);
  assign acc_up  = req_up && open;
  assign acc_dn  = req_dn && open;
  assign acc_any = acc_up || acc_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      gap_q   <= '0;
    end else begin
      if (!en_s)       start_q <= '0;
      else if (!armed) start_q <= start_q + 1'b1;

      if (acc_any)           gap_q <= GAP_LOAD;
      else if (gap_q != '0)  gap_q <= gap_q - 1'b1;
    end
  end

  // R7
  disarm_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_s && START_CYC > 0) |=> !armed);

  // R8
  gap_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_any && GAP_CYC > 1) |=> (gap_q != '0));

endmodule

// File: rtl/tlc_code_reg.sv
module tlc_code_reg #(
  parameter int CODE_W    = 8,
  parameter int INIT_CODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_up,
  input  logic              acc_dn,
  output logic [CODE_W-1:0] code,
  output logic              stb
);
  localparam logic [CODE_W-1:0] MAXC = '1;
  localparam logic [CODE_W-1:0] INIT = CODE_W'(INIT_CODE);

  logic [CODE_W-1:0] code_q;
  logic stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= INIT;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= acc_up || acc_dn;
      if (acc_up && code_q != MAXC)     code_q <= code_q + 1'b1;
      else if (acc_dn && code_q != '0)  code_q <= code_q - 1'b1;
    end
  end

  assign code = code_q;
  assign stb  = stb_q;

  // R10
  change_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != $past(code_q)) |-> stb_q);

  // R10
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);

  // R3
  top_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_up && code_q == MAXC) |=> (code_q == MAXC));

  // R3
  floor_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_dn && code_q == '0) |=> (code_q == '0));

  // R1
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != $past(code_q)) |->
      (code_q == $past(code_q) + 1'b1 || code_q == $past(code_q) - 1'b1));

endmodule

// File: rtl/tri_level_step_counter.sv
module tri_level_step_counter
  import tlc_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int INIT_CODE   = 0,
  parameter int SYNC_STAGES = 2,
  parameter int REJECT_CYC  = 20,
  parameter int VALID_CYC   = 200,
  parameter int GAP_CYC     = 10,
  parameter int START_CYC   = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              line_lo,
  input  logic              line_hi,
  output logic [CODE_W-1:0] dac_code,
  output logic              step_stb
);
  lvl_e lvl_f;
  logic en_s, req_up, req_dn, acc_up, acc_dn;

  tlc_sync_filter #(
    .SYNC_STAGES (SYNC_STAGES),
    .REJECT_CYC  (REJECT_CYC)
  ) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .lo_raw (line_lo),
    .hi_raw (line_hi),
    .en_raw (cnt_en),
    .lvl_f  (lvl_f),
    .en_s   (en_s)
  );

  tlc_width_qual #(
    .VALID_CYC (VALID_CYC)
  ) u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_f  (lvl_f),
    .req_up (req_up),
    .req_dn (req_dn)
  );

  tlc_count_gate #(
    .START_CYC (START_CYC),
    .GAP_CYC   (GAP_CYC)
  ) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_s   (en_s),
    .req_up (req_up),
    .req_dn (req_dn),
    .acc_up (acc_up),
    .acc_dn (acc_dn)
  );

  tlc_code_reg #(
    .CODE_W    (CODE_W),
    .INIT_CODE (INIT_CODE)
  ) u_code (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_up (acc_up),
    .acc_dn (acc_dn),
    .code   (dac_code),
    .stb    (step_stb)
  );

  // R6
  disabled_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_s) |=> !step_stb);

endmodule

// File: tb/tri_level_step_counter_tb.sv
module tri_level_step_counter_tb;
  localparam int CW    = 8;
  localparam int SYNC  = 2;
  localparam int REJ   = 3;
  localparam int VLD   = 12;
  localparam int GAP   = 40;
  localparam int START = 30;
  localparam int MAXC  = (1 << CW) - 1;
  localparam int QUIET = GAP + 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0;
  logic line_lo = 1'b0;
  logic line_hi = 1'b0;
  logic [CW-1:0] dac_code;
  logic step_stb;

  always #2 clk = ~clk;

  tri_level_step_counter #(
    .CODE_W(CW), .INIT_CODE(0), .SYNC_STAGES(SYNC), .REJECT_CYC(REJ),
    .VALID_CYC(VLD), .GAP_CYC(GAP), .START_CYC(START)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .line_lo(line_lo),
    .line_hi(line_hi), .dac_code(dac_code), .step_stb(step_stb)
  );

  int checks = 0;
  int errors = 0;
  int stb_seen = 0;
  int exp_code = 0;
  int exp_stb = 0;
  bit finished = 1'b0;
  bit prev_stb = 1'b0;

  // R10: strobe must never be high on two consecutive cycles
  always @(negedge clk) begin
    if (rst_n) begin
      if (step_stb) stb_seen++;
      if (step_stb && prev_stb) begin
        errors++;
        $display("FAIL R10 strobe width actual=2+ expected=1");
      end
      prev_stb = step_stb;
    end
  end

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // 0 mid, 1 low, 2 high, 3 both flags
  task automatic drive(input int lv, input int n);
    line_lo = (lv == 1 || lv == 3);
    line_hi = (lv == 2 || lv == 3);
    repeat (n) @(negedge clk);
  endtask

  function automatic int step(input int c, input int dir);
    if (dir > 0) return (c == MAXC) ? c : c + 1;
    else         return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic pulse(input int lv, input int w, input bit counts);
    drive(lv, w);
    drive(0, QUIET);
    if (counts) begin
      exp_code = step(exp_code, (lv == 1) ? 1 : -1);
      exp_stb++;
    end
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    @(negedge clk);
    drive(0, 5);
    // R11
    chk("R11 reset code", int'(dac_code), 0);
    chk("R11 reset strobe", int'(step_stb), 0);
    rst_n = 1'b1;
    cnt_en = 1'b1;
    drive(0, START + 10);

    // R3 floor
    pulse(2, VLD, 1'b1);
    chk("R3 floor code", int'(dac_code), exp_code);
    chk("R3 floor strobe", stb_seen, exp_stb);

    // R1 increments
    pulse(1, VLD, 1'b1);
    chk("R1 inc exact width", int'(dac_code), exp_code);
    pulse(1, VLD + 5, 1'b1);
    chk("R1 inc long", int'(dac_code), exp_code);

    // R2 decrement
    pulse(2, VLD + 3, 1'b1);
    chk("R2 dec", int'(dac_code), exp_code);

    // R4 short excursions
    pulse(1, VLD - 1, 1'b0);
    pulse(2, REJ + 1, 1'b0);
    chk("R4 short ignored", int'(dac_code), exp_code);

    // R5 glitches
    pulse(1, REJ - 1, 1'b0);
    chk("R5 short low blip", int'(dac_code), exp_code);
    drive(1, 6);
    drive(0, REJ - 1);
    pulse(1, 6, 1'b1);
    chk("R5 mid blip joins excursion", int'(dac_code), exp_code);

    // R9 direct low<->high
    drive(1, 8);
    pulse(2, 8, 1'b0);
    chk("R9 width restarts", int'(dac_code), exp_code);
    drive(1, VLD);
    pulse(2, VLD, 1'b1);
    chk("R9 high after low counts", int'(dac_code), exp_code);

    // R12 both flags read as mid
    drive(1, VLD);
    drive(3, 8);
    drive(0, QUIET);
    exp_code = step(exp_code, 1);
    exp_stb++;
    chk("R12 both flags as mid", int'(dac_code), exp_code);

    // R8 spacing
    drive(1, VLD);
    drive(0, REJ + 2);
    exp_code = step(exp_code, 1);
    exp_stb++;
    pulse(1, VLD, 1'b0);
    chk("R8 close count ignored", int'(dac_code), exp_code);
    pulse(1, VLD, 1'b1);
    chk("R8 spaced count", int'(dac_code), exp_code);

    // R6 disabled
    cnt_en = 1'b0;
    drive(0, 10);
    pulse(1, VLD, 1'b0);
    pulse(2, VLD + 4, 1'b0);
    chk("R6 disabled code", int'(dac_code), exp_code);
    chk("R6 disabled strobe", stb_seen, exp_stb);

    // R7 start delay
    cnt_en = 1'b1;
    pulse(1, VLD, 1'b0);
    chk("R7 early pulse ignored", int'(dac_code), exp_code);
    pulse(1, VLD, 1'b1);
    chk("R7 after delay counts", int'(dac_code), exp_code);

    // Random mix: R1 R2 R4
    for (int i = 0; i < 120; i++) begin
      int lv;
      int w;
      lv = 1 + int'($urandom_range(0, 1));
      if ($urandom_range(0, 1) == 1) w = VLD + int'($urandom_range(0, 10));
      else                           w = 1 + int'($urandom_range(0, VLD - 2));
      pulse(lv, w, w >= VLD);
      chk((lv == 1) ? "R1 random" : "R2 random", int'(dac_code), exp_code);
    end

    // R3 ceiling
    while (exp_code < MAXC) pulse(1, VLD, 1'b1);
    chk("R3 reach top", int'(dac_code), MAXC);
    pulse(1, VLD, 1'b1);
    chk("R3 top saturate", int'(dac_code), MAXC);

    // R10 total strobes
    chk("R10 strobe total", stb_seen, exp_stb);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule